// File: doc/BRIEF.md
# Flash Page Erase Controller

This block sequences page erases on a small on-chip flash array that it holds itself. Software reaches it through a narrow register port. There is a key register, a control register, an address register, a status register and a page protection mask. The control register starts locked and opens only after a two-word key sequence.

Once the control register is open, software enables erase mode, writes any word address inside the target page, and then writes the go bit. An erase on an unprotected page drives every word of that page to all ones, one word per clock, while a busy flag is raised. A completion flag marks the end.

An erase aimed at a protected page never touches the array. Instead it raises a protection error flag. Both flags are write-one-to-clear, and each drives its own interrupt line through its own enable. A read port lets the surrounding logic observe the array contents.

Top module: `flash_erase_ctrl`

## Requirements
- R1: After reset the control register reads with only its lock bit (bit 2) set, status reads zero, both interrupt lines are low, and array word i holds the value i.
- R2: Writing 0x45670123 and then 0xCDEF89AB to the key register (offset 0) unlocks control (offset 1); lock bit 2 then reads 0.
- R3: A key write whose value is not the one expected at that step locks the control register until the next reset; a later correct key pair does not unlock it, but after reset the pair works again.
- R4: Writing a 1 to control bit 2 locks the control register again, and the key pair unlocks it again.
- R5: A control write with erase-enable bit 0 and go bit 1 both set, on an unprotected page, sets all PAGE_WORDS words of the page chosen by the address register (offset 2, word address) to all ones and leaves every other word unchanged.
- R6: Status bit 0 (busy) is high for exactly PAGE_WORDS cycles, starting in the cycle after the go write; the done flag (status bit 1) sets in the cycle busy falls.
- R7: The go bit reads 0. A go is ignored while the block is locked or busy, and address and protection mask writes are ignored while busy.
- R8: When protection mask (offset 4) bit p is set, a go on page p changes no word, busy stays low, done stays clear, and the error flag (status bit 2) sets in the next cycle.
- R9: Writing 1 to status bit 1 or bit 2 clears that flag; writing 0 leaves it unchanged.
- R10: The completion interrupt equals done AND control bit 3; the error interrupt equals the error flag AND control bit 4.
- R11: A go write with erase-enable bit 0 clear starts nothing and changes no word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| mem_raddr | input | ADDR_W | Array word read address |
| mem_rdata | output | 32 | Array word read data (combinational) |
| irq_done | output | 1 | Completion interrupt |
| irq_err | output | 1 | Protection error interrupt |

## Verification
The bound checker watches the following properties on every cycle:
- an idle, locked block never raises busy;
- a busy period lasts exactly one page of cycles and always ends with the done flag set;
- a protection error never coincides with busy;
- a failed key sequence never reopens the block;
- each interrupt line agrees with its flag and enable.

Some behaviour can only be shown by the bench's scenarios. These are which words an erase touches and which it spares, the rejected go and address writes during a busy period, the W1C semantics, and recovery of the key sequence across a reset.

// File: rtl/fe_pkg.sv
package fe_pkg;
    localparam logic [2:0] OFF_KEY  = 3'd0;
    localparam logic [2:0] OFF_CTRL = 3'd1;
    localparam logic [2:0] OFF_ADDR = 3'd2;
    localparam logic [2:0] OFF_STAT = 3'd3;
    localparam logic [2:0] OFF_PROT = 3'd4;

    localparam logic [31:0] KEY_FIRST  = 32'h4567_0123;
    localparam logic [31:0] KEY_SECOND = 32'hCDEF_89AB;

    localparam int CB_ERASE = 0;
    localparam int CB_GO    = 1;
    localparam int CB_LOCK  = 2;
    localparam int CB_DIE   = 3;
    localparam int CB_EIE   = 4;

    localparam int SB_BUSY = 0;
    localparam int SB_DONE = 1;
    localparam int SB_ERR  = 2;

    typedef enum logic [1:0] {
        K_WAIT1 = 2'd0,
        K_WAIT2 = 2'd1,
        K_OPEN  = 2'd2,
        K_DEAD  = 2'd3
    } key_state_e;
endpackage

// File: rtl/fe_key_fsm.sv
module fe_key_fsm
    import fe_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        key_wr,
    input  logic [31:0] key_data,
    input  logic        relock,
    output logic        unlocked,
    output logic        dead
);
    typedef struct packed {
        key_state_e st;
    } key_regs_t;

    key_regs_t q, d;

    always_comb begin
        d = q;
        unique case (q.st)
            K_WAIT1: if (key_wr) d.st = (key_data == KEY_FIRST)  ? K_WAIT2 : K_DEAD;
            K_WAIT2: if (key_wr) d.st = (key_data == KEY_SECOND) ? K_OPEN  : K_DEAD;
            K_OPEN:  if (relock) d.st = K_WAIT1;
            default: d.st = K_DEAD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: K_WAIT1};
        else        q <= d;
    end

    assign unlocked = (q.st == K_OPEN);
    assign dead     = (q.st == K_DEAD);
endmodule

// File: rtl/fe_erase_seq.sv
module fe_erase_seq #(
    parameter int NUM_PAGES  = 8,
    parameter int PAGE_WORDS = 16,
    localparam int WOFF_W = $clog2(PAGE_WORDS),
    localparam int PG_W   = $clog2(NUM_PAGES),
    localparam int ADDR_W = PG_W + WOFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic [PG_W-1:0]   launch_page,
    output logic              busy,
    output logic              finish,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr
);
    localparam logic [WOFF_W-1:0] LAST = WOFF_W'(PAGE_WORDS - 1);

    typedef struct packed {
        logic              busy;
        logic [PG_W-1:0]   page;
        logic [WOFF_W-1:0] cnt;
    } seq_regs_t;

    seq_regs_t q, d;

    always_comb begin
        d = q;
        if (!q.busy) begin
            if (launch) begin
                d.busy = 1'b1;
                d.page = launch_page;
                d.cnt  = '0;
            end
        end else if (q.cnt == LAST) begin
            d.busy = 1'b0;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy    = q.busy;
    assign finish  = q.busy && (q.cnt == LAST);
    assign wr_en   = q.busy;
    assign wr_addr = {q.page, q.cnt};
endmodule

// File: rtl/fe_flash_array.sv
module fe_flash_array #(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 32,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= DATA_W'(i);
        end else if (wr_en) begin
            mem_q[wr_addr] <= '1;
        end
    end

    assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/flash_erase_ctrl.sv
module flash_erase_ctrl
    import fe_pkg::*;
#(
    parameter int NUM_PAGES  = 8,
    parameter int PAGE_WORDS = 16,
    localparam int WOFF_W = $clog2(PAGE_WORDS),
    localparam int PG_W   = $clog2(NUM_PAGES),
    localparam int ADDR_W = PG_W + WOFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [ADDR_W-1:0] mem_raddr,
    output logic [31:0]       mem_rdata,
    output logic              irq_done,
    output logic              irq_err
);
    typedef struct packed {
        logic                 erase_en;
        logic                 done_ie;
        logic                 err_ie;
        logic [ADDR_W-1:0]    addr;
        logic [NUM_PAGES-1:0] prot;
        logic                 flag_done;
        logic                 flag_err;
    } ctl_regs_t;

    ctl_regs_t q, d;

    logic              unlocked, key_dead, relock;
    logic              seq_busy, seq_finish, seq_wr_en, launch;
    logic [ADDR_W-1:0] seq_wr_addr;
    logic [PG_W-1:0]   page_sel;
    logic              wr_key, wr_ctrl, wr_addr, wr_stat, wr_prot, go_ok;
    logic              locked;

    assign locked   = !unlocked;
    assign page_sel = q.addr[ADDR_W-1:WOFF_W];
    assign wr_key   = reg_wr && (reg_addr == OFF_KEY);
    assign wr_ctrl  = reg_wr && (reg_addr == OFF_CTRL);
    assign wr_addr  = reg_wr && (reg_addr == OFF_ADDR);
    assign wr_stat  = reg_wr && (reg_addr == OFF_STAT);
    assign wr_prot  = reg_wr && (reg_addr == OFF_PROT);
    assign relock   = wr_ctrl && unlocked && reg_wdata[CB_LOCK];
    assign go_ok    = wr_ctrl && unlocked && !seq_busy && reg_wdata[CB_GO]
                      && reg_wdata[CB_ERASE] && !reg_wdata[CB_LOCK];

    fe_key_fsm u_key (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_wr   (wr_key),
        .key_data (reg_wdata),
        .relock   (relock),
        .unlocked (unlocked),
        .dead     (key_dead)
    );

    always_comb begin
        d      = q;
        launch = 1'b0;
        if (wr_ctrl && unlocked) begin
            d.erase_en = reg_wdata[CB_ERASE];
            d.done_ie  = reg_wdata[CB_DIE];
            d.err_ie   = reg_wdata[CB_EIE];
        end
        if (wr_addr && unlocked && !seq_busy) d.addr = reg_wdata[ADDR_W-1:0];
        if (wr_prot && unlocked && !seq_busy) d.prot = reg_wdata[NUM_PAGES-1:0];
        if (wr_stat) begin
            if (reg_wdata[SB_DONE]) d.flag_done = 1'b0;
            if (reg_wdata[SB_ERR])  d.flag_err  = 1'b0;
        end
        if (go_ok) begin
            if (q.prot[page_sel]) d.flag_err = 1'b1;
            else                  launch     = 1'b1;
        end
        if (seq_finish) d.flag_done = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    fe_erase_seq #(
        .NUM_PAGES  (NUM_PAGES),
        .PAGE_WORDS (PAGE_WORDS)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .launch      (launch),
        .launch_page (page_sel),
        .busy        (seq_busy),
        .finish      (seq_finish),
        .wr_en       (seq_wr_en),
        .wr_addr     (seq_wr_addr)
    );

    fe_flash_array #(
        .ADDR_W (ADDR_W),
        .DATA_W (32)
    ) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (seq_wr_en),
        .wr_addr (seq_wr_addr),
        .rd_addr (mem_raddr),
        .rd_data (mem_rdata)
    );

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            OFF_CTRL: begin
                reg_rdata[CB_ERASE] = q.erase_en;
                reg_rdata[CB_LOCK]  = locked;
                reg_rdata[CB_DIE]   = q.done_ie;
                reg_rdata[CB_EIE]   = q.err_ie;
            end
            OFF_ADDR: reg_rdata = 32'(q.addr);
            OFF_STAT: begin
                reg_rdata[SB_BUSY] = seq_busy;
                reg_rdata[SB_DONE] = q.flag_done;
                reg_rdata[SB_ERR]  = q.flag_err;
            end
            OFF_PROT: reg_rdata = 32'(q.prot);
            default:  reg_rdata = '0;
        endcase
    end

    assign irq_done = q.flag_done && q.done_ie;
    assign irq_err  = q.flag_err && q.err_ie;
endmodule

// File: rtl/flash_erase_ctrl_chk.sv
module flash_erase_ctrl_chk #(
    parameter int PAGE_WORDS = 16,
    localparam int RUN_W = $clog2(PAGE_WORDS) + 1
) (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic locked,
    input logic dead,
    input logic flag_done,
    input logic flag_err,
    input logic done_ie,
    input logic err_ie,
    input logic irq_done,
    input logic irq_err
);
    logic [RUN_W-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    run_q <= '0;
        else if (busy) run_q <= run_q + 1'b1;
        else           run_q <= '0;
    end

    assert_locked_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !busy) |=> !busy);

    assert_busy_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(run_q) == RUN_W'(PAGE_WORDS - 1)));

    assert_busy_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_q < RUN_W'(PAGE_WORDS)));

    assert_done_on_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> flag_done);

    assert_err_not_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_err) |-> !busy);

    assert_dead_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dead |=> (dead && locked));

    assert_irq_done_src_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_done |-> (flag_done && done_ie));

    assert_irq_done_fire_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_done && done_ie) |-> irq_done);

    assert_irq_err_src_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_err |-> (flag_err && err_ie));

    assert_irq_err_fire_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_err && err_ie) |-> irq_err);
endmodule

bind flash_erase_ctrl flash_erase_ctrl_chk #(
    .PAGE_WORDS (PAGE_WORDS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (seq_busy),
    .locked    (locked),
    .dead      (key_dead),
    .flag_done (q.flag_done),
    .flag_err  (q.flag_err),
    .done_ie   (q.done_ie),
    .err_ie    (q.err_ie),
    .irq_done  (irq_done),
    .irq_err   (irq_err)
);

// File: tb/flash_erase_ctrl_tb.sv
module flash_erase_ctrl_tb;
    localparam int NP = 8;
    localparam int PW = 16;
    localparam int AW = 7;
    localparam int DEPTH = NP * PW;

    localparam logic [2:0] A_KEY = 3'd0, A_CTRL = 3'd1, A_ADDR = 3'd2, A_STAT = 3'd3, A_PROT = 3'd4;
    localparam logic [31:0] GO_IE = 32'h1B;

    // each entry: {protection mask, target page}
    localparam int NVEC = 6;
    localparam logic [15:0] VEC [NVEC] = '{
        {8'h00, 8'd2}, {8'h08, 8'd3}, {8'h08, 8'd5},
        {8'h81, 8'd0}, {8'h81, 8'd7}, {8'h00, 8'd7}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_wr = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [AW-1:0] mem_raddr = '0;
    logic [31:0] mem_rdata;
    logic irq_done, irq_err;

    int checks = 0;
    int fails = 0;
    bit finished = 0;
    logic [31:0] exp_mem [DEPTH];

    always #5 clk = ~clk;

    flash_erase_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_raddr(mem_raddr),
        .mem_rdata(mem_rdata), .irq_done(irq_done), .irq_err(irq_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < DEPTH; i++) exp_mem[i] = 32'(i);
    endtask

    task automatic unlock();
        wr(A_KEY, 32'h4567_0123);
        wr(A_KEY, 32'hCDEF_89AB);
    endtask

    task automatic chk_mem(input string req);
        int bad = 0;
        logic [31:0] first_act = '0, first_exp = '0;
        for (int i = 0; i < DEPTH; i++) begin
            mem_raddr = AW'(i);
            #1;
            if (mem_rdata !== exp_mem[i] && bad == 0) begin
                first_act = mem_rdata; first_exp = exp_mem[i];
            end
            if (mem_rdata !== exp_mem[i]) bad++;
        end
        chk(req, first_act, first_exp);
    endtask

    task automatic erase_page(input int pg) ;
        for (int i = 0; i < PW; i++) exp_mem[pg*PW + i] = '1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int n;
        do_reset();

        // R1: reset state
        rd(A_CTRL, v); chk("R1 ctrl", v, 32'h4);
        rd(A_STAT, v); chk("R1 stat", v, 32'h0);
        chk("R1 irq", {30'd0, irq_done, irq_err}, 32'h0);
        chk_mem("R1 array");

        // R7: go while locked is ignored
        wr(A_CTRL, GO_IE);
        @(negedge clk);
        rd(A_STAT, v); chk("R7 locked go", v, 32'h0);
        rd(A_CTRL, v); chk("R7 locked ctrl", v, 32'h4);

        // R2: unlock
        unlock();
        rd(A_CTRL, v); chk("R2 unlocked", v, 32'h0);
        wr(A_CTRL, 32'h18);
        rd(A_CTRL, v); chk("R2 ctrl writable", v, 32'h18);

        // table walk: R5 R6 R8 R10
        for (int k = 0; k < NVEC; k++) begin
            logic [7:0] pm, pg;
            pm = VEC[k][15:8]; pg = VEC[k][7:0];
            wr(A_PROT, 32'(pm));
            wr(A_ADDR, 32'(pg) * PW + 5);
            wr(A_CTRL, GO_IE);
            if (pm[pg[2:0]]) begin
                rd(A_STAT, v); chk("R8 err flag", v, 32'h4);
                chk("R10 irq_err", {31'd0, irq_err}, 32'h1);
                chk("R10 irq_done quiet", {31'd0, irq_done}, 32'h0);
                chk_mem("R8 array untouched");
                wr(A_STAT, 32'h4);
            end else begin
                rd(A_STAT, v); chk("R6 busy starts", v, 32'h1);
                n = 0;
                while (v[0] && n < 40) begin
                    n++;
                    @(negedge clk);
                    rd(A_STAT, v);
                end
                chk("R6 busy length", 32'(n), 32'(PW));
                chk("R6 done set", v, 32'h2);
                chk("R10 irq_done", {31'd0, irq_done}, 32'h1);
                erase_page(pg);
                chk_mem("R5 page erased");
                wr(A_STAT, 32'h2);
            end
        end

        // R7: go and address writes during busy are ignored
        wr(A_PROT, 32'h0);
        wr(A_ADDR, 32'(1 * PW));
        wr(A_CTRL, GO_IE);
        wr(A_ADDR, 32'(6 * PW));
        wr(A_PROT, 32'hFF);
        wr(A_CTRL, GO_IE);
        rd(A_ADDR, v); chk("R7 addr held", v, 32'(1 * PW));
        rd(A_PROT, v); chk("R7 prot held", v, 32'h0);
        rd(A_CTRL, v); chk("R7 go reads 0", v & 32'h2, 32'h0);
        repeat (30) @(negedge clk);
        erase_page(1);
        chk_mem("R7 second go ignored");
        rd(A_STAT, v); chk("R7 single done", v, 32'h2);

        // R9: W1C
        wr(A_STAT, 32'h0);
        rd(A_STAT, v); chk("R9 write 0 keeps", v, 32'h2);
        wr(A_STAT, 32'h2);
        rd(A_STAT, v); chk("R9 write 1 clears", v, 32'h0);

        // R11: go without erase enable
        wr(A_ADDR, 32'(4 * PW));
        wr(A_CTRL, 32'h1A);
        rd(A_STAT, v); chk("R11 no busy", v, 32'h0);
        repeat (20) @(negedge clk);
        rd(A_STAT, v); chk("R11 no done", v, 32'h0);
        chk_mem("R11 array");

        // R10: enable off masks error interrupt
        wr(A_PROT, 32'h10);
        wr(A_CTRL, 32'h03);
        rd(A_STAT, v); chk("R10 err flag", v, 32'h4);
        chk("R10 err masked", {31'd0, irq_err}, 32'h0);
        wr(A_CTRL, 32'h10);
        chk("R10 err unmasked", {31'd0, irq_err}, 32'h1);
        wr(A_STAT, 32'h4);

        // R4: lock bit relocks; key pair reopens
        wr(A_PROT, 32'h0);
        wr(A_CTRL, 32'h04);
        rd(A_CTRL, v); chk("R4 relocked", v & 32'h4, 32'h4);
        wr(A_CTRL, GO_IE);
        rd(A_STAT, v); chk("R4 go ignored", v, 32'h0);
        unlock();
        rd(A_CTRL, v); chk("R4 reopened", v & 32'h4, 32'h0);

        // R3: wrong key locks until reset
        wr(A_CTRL, 32'h04);
        wr(A_KEY, 32'h4567_0123);
        wr(A_KEY, 32'h1234_5678);
        unlock();
        rd(A_CTRL, v); chk("R3 stays locked", v & 32'h4, 32'h4);
        wr(A_CTRL, 32'h18);
        rd(A_CTRL, v); chk("R3 ctrl ignored", v, 32'h4);
        do_reset();
        unlock();
        rd(A_CTRL, v); chk("R3 reset recovers", v, 32'h0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule